// File: doc/BRIEF.md
# Multi-Write Multi-Read RAM with Invalidation Bank Table

This block is a memory with several write ports and several read ports that all work in the same clock cycle. It is assembled only from simple two-port arrays, each with one write port and one registered read port. Every write port owns a private data bank. That bank is copied once for each read port, so no array ever sees more than one writer or more than one reader.

A bank-selection table records, for each address, which write port holds the live word. The table is also made of simple two-port arrays. Each writer keeps its own table bank and never writes into another writer's table bank. On a write, the writer first reads the other writers' table entries at that address. It then stores a value that makes the combined entries point at itself, which invalidates the older claims. The table can be encoded in binary form (the XOR of all entries gives the winning port index) or in pairwise one-hot form (each port pair keeps a bit on each side, and the reader derives a one-hot selector from them).

The write path has two stages: a table lookup, then the commit of the table and the data. The arrays forward a word that is written and read at the same address on the same edge. Because of this forwarding, a write can be read back in the next cycle.

Top module: `mprRam`

## Requirements
- R1: Each write port commits only into its own data and table banks, one cycle after the request. Writes from every port to distinct addresses in the same cycle all take effect.
- R2: Every read port works on its own and returns the live word at its address. All read ports may read any addresses in the same cycle.
- R3: Read data appears one cycle after the read address is presented. A write presented in cycle t is visible to reads presented in cycle t+1 or later. A read presented in cycle t at the address being written returns the previous word.
- R4: When different ports write one address in successive cycles, a later read returns the word from the most recent write.
- R5: In every cycle the selection logic picks exactly one write bank for each read port.
- R6: The parameter TABLE_ENC chooses the table encoding: ENC_BINARY (0) or ENC_ONEHOT (1). Both encodings give identical read data for identical stimulus.
- R7: Reset clears all data and table banks. After reset, every read returns zero from bank 0.
- R8: Reading has no side effects. With no writes, a read address that is held keeps returning the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wEn | input | NUM_WR | Write request per write port |
| wAddr | input | NUM_WR*log2(DEPTH) | Write addresses, port k at bits [k*AW +: AW] |
| wData | input | NUM_WR*WIDTH | Write data, port k at bits [k*WIDTH +: WIDTH] |
| rAddr | input | NUM_RD*log2(DEPTH) | Read addresses, port r at bits [r*AW +: AW] |
| rData | output | NUM_RD*WIDTH | Registered read data, port r at bits [r*WIDTH +: WIDTH] |

## Verification
The read-back property assumes that no two write ports target the same address in the same cycle. In that case the table contents are undefined, and no check applies. Every directed scenario gives each active write port its own address. In the random scenario the port addresses are spread at a fixed stride from a common base, so they can never collide. Both encodings are run side by side on the same stimulus and compared against one behavioural array model.

// File: rtl/mprPkg.sv
package mprPkg;
  localparam int MAX_PORTS = 8;

  typedef enum logic {
    ENC_BINARY = 1'b0,
    ENC_ONEHOT = 1'b1
  } tableEnc_e;

  // strobes from the selection control to the data banks
  typedef struct packed {
    logic [MAX_PORTS-1:0] commitWr;
  } mprStrobe_t;
endpackage

// File: rtl/mprDpArray.sv
// One write port, one registered read port; same-edge same-address read forwards new data.
module mprDpArray #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WIDTH-1:0]  rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData <= '0;
    end else begin
      if (we) mem[wrAddr] <= wrData;
      rdData <= (we && (wrAddr == rdAddr)) ? wrData : mem[rdAddr];
    end
  end
endmodule

// File: rtl/mprSelCtl.sv
// Invalidation table: one table bank per writer, copied per table consumer.
module mprSelCtl import mprPkg::*; #(
  parameter int        NUM_WR    = 3,
  parameter int        NUM_RD    = 2,
  parameter int        DEPTH     = 16,
  parameter int        ADDR_W    = 4,
  parameter tableEnc_e TABLE_ENC = ENC_BINARY
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_WR-1:0]        wEn,
  input  logic [NUM_WR*ADDR_W-1:0] wAddr,
  input  logic [NUM_RD*ADDR_W-1:0] rAddr,
  output mprStrobe_t               strobe,
  output logic [NUM_RD*NUM_WR-1:0] rdSelHot
);
  localparam int SELW   = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;
  localparam bit ONEHOT = (TABLE_ENC == ENC_ONEHOT);
  localparam int TW     = ONEHOT ? NUM_WR : SELW;
  localparam int NCOPY  = NUM_WR + NUM_RD;  // copies 0..NUM_WR-1 feed writers, rest feed readers

  logic [NUM_WR-1:0]             wEnQ;
  logic [NUM_WR-1:0][ADDR_W-1:0] wAddrQ;
  logic [TW-1:0]                 tq     [NUM_WR][NCOPY];
  logic [TW-1:0]                 newVal [NUM_WR];

  always_ff @(posedge clk) begin
    if (rst) begin
      wEnQ   <= '0;
      wAddrQ <= '0;
    end else begin
      wEnQ   <= wEn;
      wAddrQ <= wAddr;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.commitWr[NUM_WR-1:0] = wEnQ;
  end

  for (genvar j = 0; j < NUM_WR; j++) begin : gBank
    for (genvar c = 0; c < NCOPY; c++) begin : gCopy
      if (c == j) begin : gSelf
        assign tq[j][c] = '0;
      end else begin : gArr
        logic [ADDR_W-1:0] rdA;
        if (c < NUM_WR) begin : gWrSide
          assign rdA = wAddr[c*ADDR_W +: ADDR_W];
        end else begin : gRdSide
          assign rdA = rAddr[(c-NUM_WR)*ADDR_W +: ADDR_W];
        end
        mprDpArray #(.WIDTH(TW), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uTab (
          .clk(clk), .rst(rst), .we(wEnQ[j]), .wrAddr(wAddrQ[j]),
          .wrData(newVal[j]), .rdAddr(rdA), .rdData(tq[j][c])
        );
      end
    end
  end

  if (ONEHOT) begin : gHot
    // pair (i<j): i wins when bits equal; (i>j): i wins when bits differ
    logic win;
    always_comb begin
      for (int k = 0; k < NUM_WR; k++) begin
        newVal[k] = '0;
        for (int j = 0; j < NUM_WR; j++) begin
          if (j > k)      newVal[k][j] = tq[j][k][k];
          else if (j < k) newVal[k][j] = ~tq[j][k][k];
        end
      end
    end
    always_comb begin
      rdSelHot = '0;
      win = 1'b0;
      for (int r = 0; r < NUM_RD; r++) begin
        for (int i = 0; i < NUM_WR; i++) begin
          win = 1'b1;
          for (int j = 0; j < NUM_WR; j++) begin
            if (j < i)      win = win & (tq[i][NUM_WR+r][j] != tq[j][NUM_WR+r][i]);
            else if (j > i) win = win & (tq[i][NUM_WR+r][j] == tq[j][NUM_WR+r][i]);
          end
          rdSelHot[r*NUM_WR+i] = win;
        end
      end
    end
  end else begin : gBin
    // XOR of all writers' entries decodes to the live writer index
    logic [SELW-1:0] acc;
    always_comb begin
      for (int k = 0; k < NUM_WR; k++) begin
        newVal[k] = TW'(k);
        for (int j = 0; j < NUM_WR; j++)
          if (j != k) newVal[k] = newVal[k] ^ tq[j][k];
      end
    end
    always_comb begin
      rdSelHot = '0;
      acc = '0;
      for (int r = 0; r < NUM_RD; r++) begin
        acc = '0;
        for (int j = 0; j < NUM_WR; j++) acc = acc ^ tq[j][NUM_WR+r];
        for (int i = 0; i < NUM_WR; i++) rdSelHot[r*NUM_WR+i] = (acc == SELW'(i));
      end
    end
  end
endmodule

// File: rtl/mprDataBanks.sv
// Data banks: one per writer per reader, with a one-hot output select.
module mprDataBanks import mprPkg::*; #(
  parameter int NUM_WR = 3,
  parameter int NUM_RD = 2,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mprStrobe_t               strobe,
  input  logic [NUM_WR*ADDR_W-1:0] wAddr,
  input  logic [NUM_WR*WIDTH-1:0]  wData,
  input  logic [NUM_RD*ADDR_W-1:0] rAddr,
  input  logic [NUM_RD*NUM_WR-1:0] rdSelHot,
  output logic [NUM_RD*WIDTH-1:0]  rData
);
  logic [NUM_WR-1:0][ADDR_W-1:0] wAddrQ;
  logic [NUM_WR-1:0][WIDTH-1:0]  wDataQ;
  logic [WIDTH-1:0]              dq [NUM_WR][NUM_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      wAddrQ <= '0;
      wDataQ <= '0;
    end else begin
      wAddrQ <= wAddr;
      wDataQ <= wData;
    end
  end

  for (genvar k = 0; k < NUM_WR; k++) begin : gWr
    for (genvar r = 0; r < NUM_RD; r++) begin : gRd
      mprDpArray #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
        .clk(clk), .rst(rst), .we(strobe.commitWr[k]), .wrAddr(wAddrQ[k]),
        .wrData(wDataQ[k]), .rdAddr(rAddr[r*ADDR_W +: ADDR_W]), .rdData(dq[k][r])
      );
    end
  end

  if (NUM_WR < MAX_PORTS) begin : gSpare
    logic unusedHi;
    assign unusedHi = ^strobe.commitWr[MAX_PORTS-1:NUM_WR];
  end

  always_comb begin
    rData = '0;
    for (int r = 0; r < NUM_RD; r++)
      for (int k = 0; k < NUM_WR; k++)
        if (rdSelHot[r*NUM_WR+k]) rData[r*WIDTH +: WIDTH] = rData[r*WIDTH +: WIDTH] | dq[k][r];
  end
endmodule

// File: rtl/mprRam.sv
module mprRam import mprPkg::*; #(
  parameter int        NUM_WR    = 3,
  parameter int        NUM_RD    = 2,
  parameter int        DEPTH     = 16,
  parameter int        WIDTH     = 16,
  parameter tableEnc_e TABLE_ENC = ENC_BINARY
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_WR-1:0]                  wEn,
  input  logic [NUM_WR*$clog2(DEPTH)-1:0]    wAddr,
  input  logic [NUM_WR*WIDTH-1:0]            wData,
  input  logic [NUM_RD*$clog2(DEPTH)-1:0]    rAddr,
  output logic [NUM_RD*WIDTH-1:0]            rData
);
  localparam int ADDR_W = $clog2(DEPTH);

  mprStrobe_t               strobe;
  logic [NUM_RD*NUM_WR-1:0] rdSelHot;

  mprSelCtl #(
    .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TABLE_ENC(TABLE_ENC)
  ) uCtl (
    .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .rAddr(rAddr),
    .strobe(strobe), .rdSelHot(rdSelHot)
  );

  mprDataBanks #(
    .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .wAddr(wAddr), .wData(wData),
    .rAddr(rAddr), .rdSelHot(rdSelHot), .rData(rData)
  );
endmodule

// File: rtl/mprChk.sv
module mprChk #(
  parameter int NUM_WR = 3,
  parameter int NUM_RD = 2,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_WR-1:0]                wEn,
  input logic [NUM_WR*$clog2(DEPTH)-1:0]  wAddr,
  input logic [NUM_WR*WIDTH-1:0]          wData,
  input logic [NUM_RD*$clog2(DEPTH)-1:0]  rAddr,
  input logic [NUM_RD*WIDTH-1:0]          rData,
  input logic [NUM_WR-1:0]                commitWr,
  input logic [NUM_RD*NUM_WR-1:0]         rdSelHot
);
  localparam int AW = $clog2(DEPTH);

  AST_COMMIT_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    commitWr == $past(wEn)); // R1

  AST_RESET_ZERO: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> rData == '0); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wEn == '0 && $past(wEn) == '0 && $stable(rAddr)) |=> $stable(rData)); // R8

  for (genvar r = 0; r < NUM_RD; r++) begin : gRd
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(rdSelHot[r*NUM_WR +: NUM_WR]) == 1); // R5

    for (genvar k = 0; k < NUM_WR; k++) begin : gWr
      AST_RAW_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ($past(wEn[k]) && rAddr[r*AW +: AW] == $past(wAddr[k*AW +: AW]))
        |=> rData[r*WIDTH +: WIDTH] == $past(wData[k*WIDTH +: WIDTH], 2)); // R3
    end
  end
endmodule

bind mprRam mprChk #(
  .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DEPTH(DEPTH), .WIDTH(WIDTH)
) uChk (
  .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .wData(wData),
  .rAddr(rAddr), .rData(rData),
  .commitWr(strobe.commitWr[NUM_WR-1:0]), .rdSelHot(rdSelHot)
);

// File: tb/tb_mprRam.sv
`timescale 1ns/1ps
module tb_mprRam;
  localparam int NW = 3;
  localparam int NR = 2;
  localparam int DEPTH = 16;
  localparam int W = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    wEn = '0;
  logic [NW*AW-1:0] wAddr = '0;
  logic [NW*W-1:0]  wData = '0;
  logic [NR*AW-1:0] rAddr = '0;
  logic [NR*W-1:0]  rDataB;
  logic [NR*W-1:0]  rDataH;

  logic [W-1:0] model [DEPTH];
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mprRam #(.NUM_WR(NW), .NUM_RD(NR), .DEPTH(DEPTH), .WIDTH(W), .TABLE_ENC(mprPkg::ENC_BINARY)) dut (
    .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .wData(wData), .rAddr(rAddr), .rData(rDataB));

  mprRam #(.NUM_WR(NW), .NUM_RD(NR), .DEPTH(DEPTH), .WIDTH(W), .TABLE_ENC(mprPkg::ENC_ONEHOT)) dutOh (
    .clk(clk), .rst(rst), .wEn(wEn), .wAddr(wAddr), .wData(wData), .rAddr(rAddr), .rData(rDataH));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // compares both encodings against the expected word (R6)
  task automatic checkRd(int r, logic [W-1:0] exp, string tag);
    checks++;
    if (rDataB[r*W +: W] !== exp) begin
      failures++;
      $display("FAIL %s binary reader%0d: actual %h expected %h", tag, r, rDataB[r*W +: W], exp);
    end
    checks++;
    if (rDataH[r*W +: W] !== exp) begin
      failures++;
      $display("FAIL %s R6 onehot reader%0d: actual %h expected %h", tag, r, rDataH[r*W +: W], exp);
    end
  endtask

  task automatic setWrite(int k, int a, logic [W-1:0] d);
    wEn[k] = 1'b1;
    wAddr[k*AW +: AW] = AW'(a);
    wData[k*W +: W] = d;
  endtask

  task automatic testReset();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst = 1'b1;
    repeat (4) tick();
    rst = 1'b0;
    rAddr[0 +: AW] = AW'(0);
    rAddr[AW +: AW] = AW'(5);
    tick();
    checkRd(0, '0, "R7 reset");
    checkRd(1, '0, "R7 reset");
  endtask

  task automatic testRawAll();
    for (int k = 0; k < NW; k++) begin
      for (int r = 0; r < NR; r++) begin
        int a;
        logic [W-1:0] d;
        a = (k * 5 + r * 3 + 1) % DEPTH;
        d = W'(16'hA000 + k * 16 + r);
        setWrite(k, a, d);
        model[a] = d;
        tick();
        wEn = '0;
        rAddr[r*AW +: AW] = AW'(a);
        tick();
        checkRd(r, d, "R1 R2 R3 raw");
      end
    end
  endtask

  task automatic testSameCycle();
    wEn = '0;
    setWrite(0, 7, 16'h1111);
    model[7] = 16'h1111;
    tick();
    wEn = '0;
    setWrite(1, 7, 16'h2222);
    rAddr[0 +: AW] = AW'(7);
    tick();
    checkRd(0, 16'h1111, "R3 same-cycle old");
    model[7] = 16'h2222;
    wEn = '0;
    tick();
    checkRd(0, 16'h2222, "R3 next-cycle new");
  endtask

  task automatic testOrder();
    wEn = '0;
    for (int s = 0; s < NW; s++) begin
      setWrite(s, 9, W'(16'h3000 + s));
      tick();
      wEn = '0;
    end
    model[9] = W'(16'h3000 + NW - 1);
    for (int s = NW - 1; s >= 0; s--) begin
      setWrite(s, 10, W'(16'h4000 + s));
      tick();
      wEn = '0;
    end
    model[10] = 16'h4000;
    rAddr[0 +: AW] = AW'(9);
    rAddr[AW +: AW] = AW'(10);
    tick();
    checkRd(0, model[9], "R4 ascending order");
    checkRd(1, model[10], "R4 descending order");
  endtask

  // random concurrent traffic, write addresses distinct by stride (R1 R2 R5 R6)
  task automatic testRandom();
    for (int it = 0; it < 400; it++) begin
      logic [W-1:0] expV [NR];
      int base;
      base = $urandom_range(0, DEPTH - 1);
      for (int k = 0; k < NW; k++) begin
        wEn[k] = 1'($urandom_range(0, 1));
        wAddr[k*AW +: AW] = AW'((base + k * 5) % DEPTH);
        wData[k*W +: W] = W'($urandom);
      end
      for (int r = 0; r < NR; r++) begin
        rAddr[r*AW +: AW] = AW'($urandom_range(0, DEPTH - 1));
        expV[r] = model[rAddr[r*AW +: AW]];
      end
      for (int k = 0; k < NW; k++)
        if (wEn[k]) model[wAddr[k*AW +: AW]] = wData[k*W +: W];
      tick();
      for (int r = 0; r < NR; r++) checkRd(r, expV[r], "R1 R2 R5 random");
    end
    wEn = '0;
    tick();
  endtask

  task automatic testStable();
    logic [W-1:0] e0;
    logic [W-1:0] e1;
    wEn = '0;
    rAddr[0 +: AW] = AW'(3);
    rAddr[AW +: AW] = AW'(12);
    e0 = model[3];
    e1 = model[12];
    for (int i = 0; i < 3; i++) begin
      tick();
      checkRd(0, e0, "R8 hold");
      checkRd(1, e1, "R8 hold");
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testRawAll();
    testSameCycle();
    testOrder();
    testRandom();
    testStable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule